// File: doc/BRIEF.md
# Signed 32-bit ALU with Per-Operation Flag Rules

This block is the combinational integer datapath of a small processor core. It takes an operation code, a destination operand, a source operand (which also carries the shift count for shift operations) and the three condition flags currently held by the core: overflow, sign and zero. In the same cycle it returns the new result together with a result-write enable, and it returns a new value and a write enable for each flag.

Each operation decides which flags it writes. Addition, subtraction, compare and negation write all three flags. Each of them has its own overflow rule. Multiply writes only the overflow flag. The bitwise logic operations write the sign and zero flags and clear overflow, except bitwise NOT, which writes no flag. Shifts write flags only when the shift count is nonzero, and they write the overflow flag only when the count is exactly one.

When a flag's enable is low, the flag output repeats the incoming flag. The caller can therefore latch all three flag outputs every cycle, or it can use the enables.

Top module: `alu_flagged`

## Requirements
- R1: Opcode encoding on `op_i` is NEG=0, ADD=1, SUB=2, CMP=3, MUL=4, NOT=5, AND=6, OR=7, XOR=8, SAR=9, SHL=10, SHR=11. `res_we_o` is high for every defined opcode except CMP.
- R2: ADD returns the 32-bit sum of `dst_i` and `src_i`. OF is 1 exactly when both operands have the same sign and the sum's sign differs from that sign.
- R3: SUB and CMP produce `dst_i - src_i` and set OF on signed overflow. They also set OF whenever `src_i` is 0x80000000. CMP writes all three flags and holds `res_we_o` low.
- R4: NEG returns the two's complement of `dst_i`. OF is 1 exactly when `dst_i` is 0x80000000.
- R5: Whenever SF or ZF is written, SF equals bit 31 of `res_o` and ZF is 1 exactly when `res_o` is zero. NEG, ADD, SUB, CMP, AND, OR and XOR write both flags.
- R6: MUL returns the low 32 bits of the signed 64-bit product. OF is 1 when that product does not fit in a signed 32-bit value. MUL does not write SF or ZF.
- R7: AND, OR and XOR write OF as 0. NOT returns the bitwise complement of `dst_i` and writes no flag.
- R8: Shifts use only `src_i[4:0]` as the count. SAR shifts right and fills with the sign bit. SHL shifts left and fills with zeros. SHR shifts right and fills with zeros. A count of zero leaves the result equal to `dst_i` and writes no flag.
- R9: When the shift count is nonzero, SF and ZF are written. When the count is 1, OF is written: SAR writes 0, SHL writes `dst_i[31]^dst_i[30]`, and SHR writes `dst_i[31]`. For a count of 2 or more, OF is not written.
- R10: For any flag whose write enable is low, the flag output equals the corresponding incoming flag.
- R11: Opcodes 12 to 15 assert no write enable and drive `res_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| dst_i | input | 32 | Destination operand value |
| src_i | input | 32 | Source operand or shift count |
| of_i | input | 1 | Current overflow flag |
| sf_i | input | 1 | Current sign flag |
| zf_i | input | 1 | Current zero flag |
| res_o | output | 32 | Operation result |
| res_we_o | output | 1 | Result write enable |
| of_o | output | 1 | New overflow flag |
| of_we_o | output | 1 | Overflow flag write enable |
| sf_o | output | 1 | New sign flag |
| sf_we_o | output | 1 | Sign flag write enable |
| zf_o | output | 1 | New zero flag |
| zf_we_o | output | 1 | Zero flag write enable |

## Verification
The block holds no state, so any fault in the operand steering or in the flag selection shows at the ports in the same evaluation as the stimulus.

A wrong adder operand choice or a wrong carry-in shows as a wrong result or a wrong overflow flag on the very vector that exercises it.

A wrong enable decode shows as a flag output that departs from the incoming flag on a vector that should have kept it. The count-0, count-1 and count-2-or-more shift vectors are there to expose such a fault, as are the multiply vectors whose incoming sign and zero flags are set to one.

// File: rtl/alu_flagged_pkg.sv
// Package: shared operation codes for the flagged ALU.
// Assumes a 4-bit operation field; codes 12..15 are unassigned.
package alu_flagged_pkg;
    typedef enum logic [3:0] {
        OP_NEG = 4'd0,
        OP_ADD = 4'd1,
        OP_SUB = 4'd2,
        OP_CMP = 4'd3,
        OP_MUL = 4'd4,
        OP_NOT = 4'd5,
        OP_AND = 4'd6,
        OP_OR  = 4'd7,
        OP_XOR = 4'd8,
        OP_SAR = 4'd9,
        OP_SHL = 4'd10,
        OP_SHR = 4'd11
    } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
// Module: shared adder for add, subtract, compare and negate.
// Computes lhs + (invert ? ~rhs : rhs) + invert and reports the signed
// overflow of that addition. Assumes WIDTH >= 2.
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] lhs_i,
    input  logic [WIDTH-1:0] rhs_i,
    input  logic             invert_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] rhs_eff;

    // Form the effective second operand and the sum with its overflow.
    always_comb begin
        rhs_eff = invert_i ? ~rhs_i : rhs_i;
        sum_o   = lhs_i + rhs_eff + {{(WIDTH-1){1'b0}}, invert_i};
        ovf_o   = (lhs_i[MSB] == rhs_eff[MSB]) && (sum_o[MSB] != lhs_i[MSB]);
    end
endmodule

// File: rtl/alu_mul.sv
// Module: signed multiplier, low half result plus fit check.
// Assumes both operands are two's complement of WIDTH bits.
module alu_mul #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] prod_o,
    output logic             ovf_o
);
    localparam int PW = 2 * WIDTH;

    logic signed [PW-1:0] full;
    logic [WIDTH:0]       upper;

    // Full-width product; overflow when the top WIDTH+1 bits disagree.
    always_comb begin
        full   = PW'($signed(a_i)) * PW'($signed(b_i));
        upper  = full[PW-1:WIDTH-1];
        prod_o = full[WIDTH-1:0];
        ovf_o  = !((&upper) || !(|upper));
    end
endmodule

// File: rtl/alu_logic.sv
// Module: bitwise unit (NOT, AND, OR, XOR) selected by a 2-bit code.
// Code 0 = NOT of a, 1 = AND, 2 = OR, 3 = XOR.
module alu_logic #(
    parameter int WIDTH = 32
) (
    input  logic [1:0]       sel_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o
);
    // Pick the bitwise function.
    always_comb begin
        case (sel_i)
            2'd0:    res_o = ~a_i;
            2'd1:    res_o = a_i & b_i;
            2'd2:    res_o = a_i | b_i;
            default: res_o = a_i ^ b_i;
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
// Module: barrel shifter for arithmetic right, logical left, logical right.
// Code 0 = arithmetic right, 1 = left, 2/3 = logical right. Reports
// whether the count is nonzero, whether it is one, and the OF value
// that a count of one produces.
module alu_shift #(
    parameter int WIDTH = 32,
    parameter int SH_W  = $clog2(WIDTH)
) (
    input  logic [1:0]       sel_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [SH_W-1:0]  amt_i,
    output logic [WIDTH-1:0] res_o,
    output logic             nz_o,
    output logic             one_o,
    output logic             ovf1_o
);
    localparam int MSB = WIDTH - 1;

    // Shift result and the overflow value tied to a count of one.
    always_comb begin
        nz_o  = |amt_i;
        one_o = (amt_i == SH_W'(1));
        case (sel_i)
            2'd0: begin
                res_o  = WIDTH'($signed(a_i) >>> amt_i);
                ovf1_o = 1'b0;
            end
            2'd1: begin
                res_o  = a_i << amt_i;
                ovf1_o = a_i[MSB] ^ a_i[MSB-1];
            end
            default: begin
                res_o  = a_i >> amt_i;
                ovf1_o = a_i[MSB];
            end
        endcase
    end
endmodule

// File: rtl/alu_flagged.sv
// Module: top of the flagged ALU. Steers operands to the shared units,
// selects the result and decides per operation which flags are written.
// Purely combinational; unwritten flags pass through from the inputs.
module alu_flagged #(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] dst_i,
    input  logic [WIDTH-1:0] src_i,
    input  logic             of_i,
    input  logic             sf_i,
    input  logic             zf_i,
    output logic [WIDTH-1:0] res_o,
    output logic             res_we_o,
    output logic             of_o,
    output logic             of_we_o,
    output logic             sf_o,
    output logic             sf_we_o,
    output logic             zf_o,
    output logic             zf_we_o
);
    import alu_flagged_pkg::*;

    localparam int              MSB     = WIDTH - 1;
    localparam int              SH_W    = $clog2(WIDTH);
    localparam logic [WIDTH-1:0] MIN_VAL = {1'b1, {(WIDTH-1){1'b0}}};

    alu_op_e          op;
    logic [WIDTH-1:0] as_lhs, as_rhs, as_sum;
    logic             as_inv, as_ovf;
    logic [WIDTH-1:0] mul_res;
    logic             mul_ovf;
    logic [1:0]       lg_sel, sh_sel;
    logic [WIDTH-1:0] lg_res, sh_res;
    logic             sh_nz, sh_one, sh_ovf1;
    logic             of_val;

    // Decode the opcode and steer the adder operands.
    always_comb begin
        op     = alu_op_e'(op_i);
        as_lhs = (op == OP_NEG) ? '0 : dst_i;
        as_rhs = (op == OP_NEG) ? dst_i : src_i;
        as_inv = (op != OP_ADD);
        lg_sel = op_i[1:0] - 2'd1;
        sh_sel = op_i[1:0] - 2'd1;
    end

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .lhs_i(as_lhs), .rhs_i(as_rhs), .invert_i(as_inv),
        .sum_o(as_sum), .ovf_o(as_ovf)
    );

    alu_mul #(.WIDTH(WIDTH)) u_mul (
        .a_i(dst_i), .b_i(src_i), .prod_o(mul_res), .ovf_o(mul_ovf)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .sel_i(lg_sel), .a_i(dst_i), .b_i(src_i), .res_o(lg_res)
    );

    alu_shift #(.WIDTH(WIDTH), .SH_W(SH_W)) u_shift (
        .sel_i(sh_sel), .a_i(dst_i), .amt_i(src_i[SH_W-1:0]),
        .res_o(sh_res), .nz_o(sh_nz), .one_o(sh_one), .ovf1_o(sh_ovf1)
    );

    // Select result and per-operation write enables.
    always_comb begin
        res_o    = '0;
        res_we_o = 1'b0;
        of_we_o  = 1'b0;
        sf_we_o  = 1'b0;
        zf_we_o  = 1'b0;
        of_val   = of_i;
        case (op)
            OP_NEG, OP_ADD: begin
                res_o    = as_sum;
                res_we_o = 1'b1;
                {of_we_o, sf_we_o, zf_we_o} = 3'b111;
                of_val   = as_ovf;
            end
            OP_SUB, OP_CMP: begin
                res_o    = as_sum;
                res_we_o = (op == OP_SUB);
                {of_we_o, sf_we_o, zf_we_o} = 3'b111;
                of_val   = as_ovf || (src_i == MIN_VAL);
            end
            OP_MUL: begin
                res_o    = mul_res;
                res_we_o = 1'b1;
                of_we_o  = 1'b1;
                of_val   = mul_ovf;
            end
            OP_NOT: begin
                res_o    = lg_res;
                res_we_o = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR: begin
                res_o    = lg_res;
                res_we_o = 1'b1;
                {of_we_o, sf_we_o, zf_we_o} = 3'b111;
                of_val   = 1'b0;
            end
            OP_SAR, OP_SHL, OP_SHR: begin
                res_o    = sh_res;
                res_we_o = 1'b1;
                sf_we_o  = sh_nz;
                zf_we_o  = sh_nz;
                of_we_o  = sh_one;
                of_val   = sh_ovf1;
            end
            default: ;
        endcase
    end

    // Merge written flag values with the incoming flags.
    always_comb begin
        of_o = of_we_o ? of_val : of_i;
        sf_o = sf_we_o ? res_o[MSB] : sf_i;
        zf_o = zf_we_o ? (res_o == '0) : zf_i;
    end
endmodule

// File: rtl/alu_flagged_checker.sv
// Module: property checker for alu_flagged, attached with bind.
// Assumes the block is combinational; checks are immediate and re-evaluate
// whenever any port changes.
module alu_flagged_checker #(
    parameter int WIDTH = 32
) (
    input logic [3:0]       op_i,
    input logic [WIDTH-1:0] dst_i,
    input logic [WIDTH-1:0] src_i,
    input logic             of_i,
    input logic             sf_i,
    input logic             zf_i,
    input logic [WIDTH-1:0] res_o,
    input logic             res_we_o,
    input logic             of_o,
    input logic             of_we_o,
    input logic             sf_o,
    input logic             sf_we_o,
    input logic             zf_o,
    input logic             zf_we_o
);
    localparam logic [WIDTH-1:0] MIN_VAL = {1'b1, {(WIDTH-1){1'b0}}};
    localparam int               SH_W    = $clog2(WIDTH);

    logic signed [WIDTH:0] wide_sum;
    logic                  is_shift;

    // Independent reference terms and the port-level properties.
    always_comb begin
        wide_sum = $signed({dst_i[WIDTH-1], dst_i}) + $signed({src_i[WIDTH-1], src_i});
        is_shift = (op_i >= 4'd9) && (op_i <= 4'd11);
        if (op_i == 4'd0 && dst_i == MIN_VAL)
            AST_NEG_MIN_OVF: assert (of_we_o && of_o);                           // R4
        if (op_i == 4'd1)
            AST_ADD_OVF: assert (of_o == (wide_sum[WIDTH] != wide_sum[WIDTH-1])); // R2
        if (op_i == 4'd3)
            AST_CMP_NO_WRITE: assert (!res_we_o && of_we_o && sf_we_o && zf_we_o); // R3
        if (op_i == 4'd4)
            AST_MUL_KEEPS_SZ: assert (!sf_we_o && !zf_we_o && of_we_o);            // R6
        if (op_i >= 4'd6 && op_i <= 4'd8)
            AST_LOGIC_CLR_OF: assert (of_we_o && !of_o);                           // R7
        if (is_shift && src_i[SH_W-1:0] == '0)
            AST_SHIFT_ZERO_HOLD: assert (!of_we_o && !sf_we_o && !zf_we_o && res_o == dst_i); // R8
        if (is_shift && src_i[SH_W-1:0] > SH_W'(1))
            AST_SHIFT_OF_ONLY_ONE: assert (!of_we_o && sf_we_o);                  // R9
        if (zf_we_o)
            AST_ZF_MATCH: assert (zf_o == (res_o == '0));                         // R5
        if (!of_we_o)
            AST_OF_PASS: assert (of_o == of_i);                                   // R10
        if (!sf_we_o)
            AST_SF_PASS: assert (sf_o == sf_i);                                   // R10
        if (!zf_we_o)
            AST_ZF_PASS: assert (zf_o == zf_i);                                   // R10
        if (op_i >= 4'd12)
            AST_UNUSED_OP_IDLE: assert (!res_we_o && !of_we_o && !sf_we_o && !zf_we_o); // R11
    end
endmodule

bind alu_flagged alu_flagged_checker #(.WIDTH(WIDTH)) u_alu_flagged_checker (
    .op_i(op_i), .dst_i(dst_i), .src_i(src_i),
    .of_i(of_i), .sf_i(sf_i), .zf_i(zf_i),
    .res_o(res_o), .res_we_o(res_we_o),
    .of_o(of_o), .of_we_o(of_we_o),
    .sf_o(sf_o), .sf_we_o(sf_we_o),
    .zf_o(zf_o), .zf_we_o(zf_we_o)
);

// File: tb/alu_flagged_bench.sv
// Bench: table-driven check of alu_flagged followed by directed sweeps.
// Vector layout: op(4) dst(32) src(32) flags_in{of,sf,zf}(3)
//                res(32) we{res,of,sf,zf}(4) flags_out{of,sf,zf}(3)
module alu_flagged_bench;
    localparam int W  = 32;
    localparam int NV = 29;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [3:0]   op;
    logic [W-1:0] dst, src, res;
    logic         of_i, sf_i, zf_i;
    logic         res_we, of_o, of_we, sf_o, sf_we, zf_o, zf_we;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    alu_flagged #(.WIDTH(W)) u_alu_flagged (
        .op_i(op), .dst_i(dst), .src_i(src),
        .of_i(of_i), .sf_i(sf_i), .zf_i(zf_i),
        .res_o(res), .res_we_o(res_we),
        .of_o(of_o), .of_we_o(of_we),
        .sf_o(sf_o), .sf_we_o(sf_we),
        .zf_o(zf_o), .zf_we_o(zf_we)
    );

    localparam logic [109:0] VEC [NV] = '{
        {4'd1,  32'h00000005, 32'h00000003, 3'b000, 32'h00000008, 4'b1111, 3'b000},
        {4'd1,  32'h7FFFFFFF, 32'h00000001, 3'b000, 32'h80000000, 4'b1111, 3'b110},
        {4'd1,  32'hFFFFFFFF, 32'h00000001, 3'b000, 32'h00000000, 4'b1111, 3'b001},
        {4'd1,  32'h80000000, 32'h80000000, 3'b000, 32'h00000000, 4'b1111, 3'b101},
        {4'd2,  32'h00000003, 32'h00000005, 3'b000, 32'hFFFFFFFE, 4'b1111, 3'b010},
        {4'd2,  32'h80000000, 32'h00000001, 3'b000, 32'h7FFFFFFF, 4'b1111, 3'b100},
        {4'd2,  32'hFFFFFFFF, 32'h80000000, 3'b000, 32'h7FFFFFFF, 4'b1111, 3'b100},
        {4'd3,  32'h00000005, 32'h00000005, 3'b110, 32'h00000000, 4'b0111, 3'b001},
        {4'd0,  32'h80000000, 32'h00000000, 3'b000, 32'h80000000, 4'b1111, 3'b110},
        {4'd0,  32'h00000005, 32'h00000000, 3'b000, 32'hFFFFFFFB, 4'b1111, 3'b010},
        {4'd0,  32'h00000000, 32'h00000000, 3'b100, 32'h00000000, 4'b1111, 3'b001},
        {4'd4,  32'h00010000, 32'h00010000, 3'b011, 32'h00000000, 4'b1100, 3'b111},
        {4'd4,  32'hFFFFFFFF, 32'hFFFFFFFE, 3'b011, 32'h00000002, 4'b1100, 3'b011},
        {4'd5,  32'h0F0F0F0F, 32'h00000000, 3'b101, 32'hF0F0F0F0, 4'b1000, 3'b101},
        {4'd6,  32'hF0F0FFFF, 32'h0F0F0000, 3'b110, 32'h00000000, 4'b1111, 3'b001},
        {4'd7,  32'h80000000, 32'h00000001, 3'b100, 32'h80000001, 4'b1111, 3'b010},
        {4'd8,  32'h12345678, 32'h12345678, 3'b100, 32'h00000000, 4'b1111, 3'b001},
        {4'd9,  32'h80000000, 32'h00000001, 3'b100, 32'hC0000000, 4'b1111, 3'b010},
        {4'd9,  32'h80000000, 32'h00000004, 3'b100, 32'hF8000000, 4'b1011, 3'b110},
        {4'd10, 32'h40000000, 32'h00000001, 3'b000, 32'h80000000, 4'b1111, 3'b110},
        {4'd10, 32'hC0000000, 32'h00000001, 3'b100, 32'h80000000, 4'b1111, 3'b010},
        {4'd10, 32'h00000001, 32'h00000021, 3'b111, 32'h00000002, 4'b1111, 3'b000},
        {4'd10, 32'h00000001, 32'h00000020, 3'b011, 32'h00000001, 4'b1000, 3'b011},
        {4'd11, 32'h80000000, 32'h00000001, 3'b000, 32'h40000000, 4'b1111, 3'b100},
        {4'd11, 32'h80000000, 32'h0000001F, 3'b001, 32'h00000001, 4'b1011, 3'b000},
        {4'd11, 32'h00000001, 32'h00000001, 3'b110, 32'h00000000, 4'b1111, 3'b001},
        {4'd12, 32'h12345678, 32'h00000001, 3'b101, 32'h00000000, 4'b0000, 3'b101},
        {4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 3'b010, 32'h00000000, 4'b0000, 3'b010},
        {4'd9,  32'h00000005, 32'h00000000, 3'b110, 32'h00000005, 4'b1000, 3'b110}
    };

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd0:             return "R4";
            4'd1:             return "R2";
            4'd2, 4'd3:       return "R3";
            4'd4:             return "R6";
            4'd5, 4'd6, 4'd7, 4'd8: return "R7";
            4'd9, 4'd10, 4'd11:     return "R9";
            default:          return "R11";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] o, input logic [W-1:0] d,
                         input logic [W-1:0] s, input logic [2:0] f);
        @(posedge clk);
        op = o; dst = d; src = s; {of_i, sf_i, zf_i} = f;
        @(negedge clk);
    endtask

    initial begin
        op = 4'd12; dst = '0; src = '0; {of_i, sf_i, zf_i} = 3'b000;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // Idle state: unassigned opcode writes nothing (R11)
        apply(4'd12, 32'h0, 32'h0, 3'b111);
        check("R11", "idle we", {60'd0, res_we, of_we, sf_we, zf_we}, 64'd0);
        check("R10", "idle flags", {61'd0, of_o, sf_o, zf_o}, 64'd7);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [109:0] v;
            string r;
            v = VEC[i];
            r = req_of(v[109:106]);
            apply(v[109:106], v[105:74], v[73:42], v[41:39]);
            check(r, $sformatf("vec%0d res", i), {32'd0, res}, {32'd0, v[38:7]});
            check(v[109:106] == 4'd3 ? "R3" : "R1", $sformatf("vec%0d we", i),
                  {60'd0, res_we, of_we, sf_we, zf_we}, {60'd0, v[6:3]});
            check(v[6:3] == 4'b1111 ? "R5" : "R10", $sformatf("vec%0d flags", i),
                  {61'd0, of_o, sf_o, zf_o}, {61'd0, v[2:0]});
        end

        // Directed: shift count sweep on SHL uses only low count bits (R8)
        for (int a = 0; a < 64; a++) begin
            logic [W-1:0] e;
            e = 32'hA5000001 << (a % 32);
            apply(4'd10, 32'hA5000001, 32'(a), 3'b010);
            check("R8", $sformatf("shl amt %0d", a), {32'd0, res}, {32'd0, e});
            check("R8", $sformatf("shl amt %0d sfwe", a), {63'd0, sf_we}, {63'd0, (a % 32) != 0});
        end

        // Directed: add overflow against wide arithmetic (R2)
        for (int k = 0; k < 16; k++) begin
            logic [W-1:0] d, s;
            longint wide;
            d = 32'h9E3779B9 * (k + 1);
            s = 32'h7F4A7C15 * (k + 3);
            wide = longint'($signed(d)) + longint'($signed(s));
            apply(4'd1, d, s, 3'b000);
            check("R2", $sformatf("add sweep %0d", k), {31'd0, of_o, res},
                  {31'd0, (wide > 64'sd2147483647) || (wide < -64'sd2147483648), d + s});
        end

        // Directed: multiply overflow at the boundary (R6)
        apply(4'd4, 32'h00010000, 32'h00007FFF, 3'b000);
        check("R6", "mul fits", {31'd0, of_o, res}, {31'd0, 1'b0, 32'h7FFF0000});
        apply(4'd4, 32'h80000000, 32'hFFFFFFFF, 3'b000);
        check("R6", "mul min*-1", {31'd0, of_o, res}, {31'd0, 1'b1, 32'h80000000});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule